// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block decides, one clock at a time, how each bus cycle of a processor ends. A requester offers a cycle with its direction, transfer type, a flag marking it as part of a locked read-modify-write sequence and a flag marking the final transfer of that sequence. Once a cycle is running, the controller samples the transfer-acknowledge input at every rising edge. A cycle ends on the edge where the acknowledge is seen high. If another request is waiting on that same edge, it is taken at once and the transfer-in-progress output never drops. If no request is waiting, transfer-in-progress goes low.

The data-bus output enable covers write cycles only and is released on the clock after a write ends. Two lock outputs cover a read-modify-write sequence, and each has its own release rule. The lock output holds through idle gaps and drops only when a cycle that is not part of a locked sequence starts. The lock-end output marks only the final write of the sequence and drops as soon as that write is acknowledged. Acknowledge cycles (transfer type 2'b11) are handled as reads.

A request is taken on an edge where `req_valid_i` is high and either no cycle is running or `ta_i` is high. The requester can form this condition from `tip_o` and `ta_i`. It holds its request until that edge.

Top module: `bus_term_ctrl`

## Requirements
- R1: While `rst_ni` is low, `tip_o`, `dbe_o`, `lock_o` and `locke_o` are 0 and `tt_o` is 2'b00.
- R2: With no cycle running, a high `req_valid_i` at a rising edge starts a cycle. After that edge `tip_o` is 1 and `tt_o` equals the `req_tt_i` that was sampled at the edge.
- R3: A running cycle continues while `ta_i` is low at each edge. `tip_o` stays 1 and `tt_o` does not change.
- R4: If `ta_i` and `req_valid_i` are both high at an edge during a running cycle, the next cycle starts at that edge. `tip_o` stays 1 with no gap, and `tt_o` takes the new type.
- R5: If `ta_i` is high and `req_valid_i` is low at an edge during a running cycle, `tip_o` is 0 after that edge.
- R6: `dbe_o` is 1 from the start of a write cycle (`req_write_i`=1) until it ends. It is 0 after the ending edge unless the cycle started at that edge is also a write.
- R7: `lock_o` becomes 1 when a cycle with `req_rmw_i`=1 starts. It stays 1 through idle time. It becomes 0 only when a cycle with `req_rmw_i`=0 starts.
- R8: `locke_o` is 1 during a cycle that started with `req_rmw_i`, `req_write_i` and `req_last_i` all 1. It is 0 after the edge that acknowledges that cycle.
- R9: `ta_i` is ignored while no cycle is running. `tip_o`, `dbe_o`, `lock_o` and `locke_o` do not change.
- R10: A cycle with `req_tt_i`=2'b11 (acknowledge cycle) is treated as a read. It never sets `dbe_o`, `lock_o` or `locke_o`, and `tt_o` shows 2'b11 while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A cycle is ready to start |
| req_write_i | input | 1 | Offered cycle is a write |
| req_rmw_i | input | 1 | Offered cycle belongs to a locked read-modify-write sequence |
| req_last_i | input | 1 | Offered cycle is the last transfer of its sequence |
| req_tt_i | input | 2 | Transfer type of the offered cycle |
| ta_i | input | 1 | Transfer acknowledge |
| tip_o | output | 1 | Transfer in progress |
| dbe_o | output | 1 | Data-bus output enable |
| lock_o | output | 1 | Locked sequence indicator |
| locke_o | output | 1 | Final write of a locked sequence |
| tt_o | output | 2 | Transfer type of the running cycle |

## Verification
Every output is a register, so each effect of a request or an acknowledge is due one rising edge after the edge where it is sampled. No output ever reacts combinationally. The bench changes inputs on the falling edge and applies one edge per step. It checks the outputs 1 ns after that edge, so each check reads the first value produced by the stimulus and never a later one. Sequences that span several cycles are built from such steps and checked at every step. This covers the lock output holding through idle gaps and the release of the enable on the clock after a write.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;
  localparam int unsigned TT_W = 2;
  typedef logic [TT_W-1:0] tt_t;
  localparam tt_t TT_ACK  = 2'b11;
  localparam tt_t TT_IDLE = 2'b00;
endpackage

// File: rtl/bus_term_seq.sv
module bus_term_seq
  import bus_term_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  tt_t  req_tt_i,
  input  logic ta_i,
  output logic load_o,
  output logic end_o,
  output logic tip_o,
  output tt_t  tt_o
);
  logic tip_q;
  tt_t  tt_q;

  assign end_o  = tip_q & ta_i;
  assign load_o = req_valid_i & (~tip_q | ta_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tip_q <= 1'b0;
      tt_q  <= TT_IDLE;
    end else if (load_o) begin
      tip_q <= 1'b1;
      tt_q  <= req_tt_i;
    end else if (end_o) begin
      tip_q <= 1'b0;
    end
  end

  assign tip_o = tip_q;
  assign tt_o  = tt_q;

  // R3
  hold_tt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_q && !ta_i) |=> (tip_q && $stable(tt_q)));
  // R5
  idle_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_q && ta_i && !req_valid_i) |=> !tip_q);
  // R9
  idle_ta_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tip_q && !req_valid_i) |=> !tip_q);
  // R4
  no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_q && ta_i && req_valid_i) |=> (tip_q && tt_q == $past(req_tt_i)));
endmodule

// File: rtl/bus_term_dbe.sv
module bus_term_dbe
  import bus_term_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic end_i,
  input  logic req_write_i,
  input  tt_t  req_tt_i,
  output logic dbe_o
);
  logic dbe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dbe_q <= 1'b0;
    else if (load_i) dbe_q <= req_write_i & (req_tt_i != TT_ACK);
    else if (end_i)  dbe_q <= 1'b0;
  end

  assign dbe_o = dbe_q;

  // R6
  dbe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !load_i) |=> !dbe_q);
  // R10
  ack_no_dbe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && req_tt_i == TT_ACK) |=> !dbe_q);
endmodule

// File: rtl/bus_term_lock.sv
module bus_term_lock
  import bus_term_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic end_i,
  input  logic req_write_i,
  input  logic req_rmw_i,
  input  logic req_last_i,
  input  tt_t  req_tt_i,
  output logic lock_o,
  output logic locke_o
);
  logic lock_q, locke_q, locked_req;

  assign locked_req = req_rmw_i & (req_tt_i != TT_ACK);

  // lock released only by a non-locked cycle start; lock-end by its own ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      locke_q <= 1'b0;
    end else if (load_i) begin
      lock_q  <= locked_req;
      locke_q <= locked_req & req_write_i & req_last_i;
    end else if (end_i) begin
      locke_q <= 1'b0;
    end
  end

  assign lock_o  = lock_q;
  assign locke_o = locke_q;

  // R8
  locke_in_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locke_q |-> lock_q);
  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !load_i) |=> lock_q);
  // R8
  locke_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !load_i) |=> !locke_q);
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bus_term_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic            req_rmw_i,
  input  logic            req_last_i,
  input  logic [TT_W-1:0] req_tt_i,
  input  logic            ta_i,
  output logic            tip_o,
  output logic            dbe_o,
  output logic            lock_o,
  output logic            locke_o,
  output logic [TT_W-1:0] tt_o
);
  logic load, cyc_end;

  bus_term_seq u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_tt_i, .ta_i,
    .load_o(load), .end_o(cyc_end), .tip_o, .tt_o
  );

  bus_term_dbe u_dbe (
    .clk_i, .rst_ni, .load_i(load), .end_i(cyc_end),
    .req_write_i, .req_tt_i, .dbe_o
  );

  bus_term_lock u_lock (
    .clk_i, .rst_ni, .load_i(load), .end_i(cyc_end),
    .req_write_i, .req_rmw_i, .req_last_i, .req_tt_i, .lock_o, .locke_o
  );

  // R6
  dbe_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbe_o |-> tip_o);
  // R9
  idle_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tip_o && !req_valid_i) |=> ($stable(lock_o) && !dbe_o && !locke_o));
  // R1
  reset_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!tip_o && !dbe_o && !lock_o && !locke_o));
endmodule

// File: tb/bus_term_ctrl_bench.sv
`timescale 1ns/1ps
module bus_term_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, wr = 0, rmw = 0, last = 0, ta = 0;
  logic [1:0] tt = 2'b00;
  logic tip, dbe, lock, locke;
  logic [1:0] tt_out;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  bus_term_ctrl u_bus_term_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr),
    .req_rmw_i(rmw), .req_last_i(last), .req_tt_i(tt), .ta_i(ta),
    .tip_o(tip), .dbe_o(dbe), .lock_o(lock), .locke_o(locke), .tt_o(tt_out)
  );

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // drive on falling edge, take one rising edge, sample 1 ns later
  task automatic step(logic v, logic w, logic r, logic l, logic [1:0] t, logic a);
    @(negedge clk);
    valid = v; wr = w; rmw = r; last = l; tt = t; ta = a;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_out();
    step(0, 0, 0, 0, 2'b00, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 tip", tip, 0); chk("R1 dbe", dbe, 0);
    chk("R1 lock", lock, 0); chk("R1 locke", locke, 0); chk("R1 tt", tt_out, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_single_read();
    step(1, 0, 0, 0, 2'b01, 0);
    chk("R2 tip", tip, 1); chk("R2 tt", tt_out, 2'b01); chk("R6 dbe read", dbe, 0);
    step(0, 0, 0, 0, 2'b10, 0);
    chk("R3 tip hold", tip, 1); chk("R3 tt hold", tt_out, 2'b01);
    step(0, 0, 0, 0, 2'b00, 0);
    chk("R3 tip hold2", tip, 1);
    step(0, 0, 0, 0, 2'b00, 1);
    chk("R5 tip drop", tip, 0);
  endtask

  task automatic t_writes();
    step(1, 1, 0, 0, 2'b00, 0);
    chk("R6 dbe on", dbe, 1);
    step(1, 1, 0, 0, 2'b10, 1);
    chk("R4 tip kept", tip, 1); chk("R4 tt new", tt_out, 2'b10); chk("R6 dbe w-w", dbe, 1);
    step(1, 0, 0, 0, 2'b01, 1);
    chk("R4 tip kept2", tip, 1); chk("R6 dbe w-r", dbe, 0); chk("R4 tt", tt_out, 2'b01);
    step(1, 1, 0, 0, 2'b00, 1);
    chk("R6 dbe r-w", dbe, 1);
    step(0, 0, 0, 0, 2'b00, 1);
    chk("R6 dbe off", dbe, 0); chk("R5 tip", tip, 0);
  endtask

  task automatic t_rmw();
    step(1, 0, 1, 0, 2'b00, 0);
    chk("R7 lock on", lock, 1); chk("R8 locke off read", locke, 0);
    step(1, 1, 1, 1, 2'b00, 1);
    chk("R7 lock held", lock, 1); chk("R8 locke on", locke, 1); chk("R6 dbe", dbe, 1);
    step(0, 0, 0, 0, 2'b00, 0);
    chk("R8 locke stays", locke, 1);
    step(0, 0, 0, 0, 2'b00, 1);
    chk("R8 locke off", locke, 0); chk("R7 lock idle", lock, 1); chk("R5 tip", tip, 0);
    idle_out();
    chk("R7 lock gap", lock, 1);
    step(0, 0, 0, 0, 2'b00, 1);
    chk("R9 tip", tip, 0); chk("R9 lock", lock, 1); chk("R9 dbe", dbe, 0); chk("R9 locke", locke, 0);
    step(1, 0, 0, 0, 2'b00, 0);
    chk("R7 lock off", lock, 0);
    step(0, 0, 0, 0, 2'b00, 1);
  endtask

  task automatic t_ack_cycle();
    step(1, 1, 1, 1, 2'b11, 0);
    chk("R10 tt", tt_out, 2'b11); chk("R10 dbe", dbe, 0);
    chk("R10 lock", lock, 0); chk("R10 locke", locke, 0);
    step(0, 0, 0, 0, 2'b00, 1);
    chk("R10 end", tip, 0);
  endtask

  initial begin
    #200000;
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single_read();
    t_writes();
    t_rmw();
    t_ack_cycle();
    idle_out();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule